// File: doc/BRIEF.md
# Idle Countdown Timer with Activity Reload

This block measures how long a system has been inactive. Software programs an 8-bit start count. The counter then steps down by one on every one-minute tick. When it reaches zero, the block sends a single-cycle expiry pulse to the system-management interrupt controller.

Any activity event that software has enabled reloads the counter to the programmed start count. The activity events are interrupt requests, the non-maskable interrupt and the management interrupt itself. While the system stays active, the counter therefore never runs out.

The block also holds a two-state power mode, Power On or Fast Off. Only a software write puts the mode into Fast Off. Any enabled break event returns it to Power On in hardware.

Activity events are selected by a 9-bit mask and break events by their own mask. The minute tick is supplied from outside the block as a one-cycle strobe.

Top module: `idle_reload_timer`

## Requirements
- R1: After reset the counter and the start count are zero, both masks are clear, the mode is Power On (`fastOff` = 0) and `expirePulse` is low.
- R2: A cycle with `wrStart` high stores `startData` as the start count and loads it into the counter at the same clock edge.
- R3: Each cycle with `minuteTick` high and a nonzero counter lowers the counter by one. A counter at zero stays at zero. After a load of N, the Nth tick is the one that empties the counter.
- R4: `expirePulse` is high for exactly one cycle, in the cycle after the tick edge that takes the counter from 1 to 0. No further pulse occurs until the counter is loaded or reloaded.
- R5: Activity input bit k maps to these sources: bit 0 IRQ0, bit 1 IRQ1, bit 2 IRQ3, bit 3 IRQ7, bit 4 IRQ8, bit 5 IRQ9, bit 6 IRQ15, bit 7 NMI, bit 8 SMI. An activity bit that is high while its mask bit (written through `wrActMask`) is set reloads the counter with the start count. This also applies after expiry.
- R6: An activity bit whose mask bit is clear has no effect on the counter.
- R7: Priority in a single cycle is start write first, then activity reload, then tick. A tick that coincides with a reload or a start write is lost.
- R8: A start count of zero is an invalid programming. It leaves the counter at zero and never produces an expiry pulse, whether the zero is loaded or reloaded.
- R9: A cycle with `wrMode` high sets `fastOff` to `modeData` at that edge.
- R10: A break bit that is high while its break-mask bit (written through `wrBrkMask`) is set clears `fastOff` at that edge. This takes precedence over a simultaneous `wrMode` of 1.
- R11: A break bit whose mask bit is clear, and any activity event, leave `fastOff` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrStart | input | 1 | Write strobe for the start count |
| startData | input | 8 | Start count value |
| wrActMask | input | 1 | Write strobe for the activity mask |
| actMaskData | input | 9 | Activity mask value, bit order as in R5 |
| wrBrkMask | input | 1 | Write strobe for the break mask |
| brkMaskData | input | 4 | Break mask value |
| wrMode | input | 1 | Write strobe for the mode bit |
| modeData | input | 1 | 1 selects Fast Off, 0 selects Power On |
| actEvt | input | 9 | Activity event levels, bit order as in R5 |
| brkEvt | input | 4 | Break event levels |
| minuteTick | input | 1 | One-cycle strobe, once per minute |
| expirePulse | output | 1 | Single-cycle idle-expiry pulse |
| fastOff | output | 1 | Current mode, 1 = Fast Off |

## Verification
The counter has no output port, so a wrong internal count shows up at the ports only as a shift in the tick on which `expirePulse` fires. A lost or spurious reload shows up the same way. Such an error can stay hidden for up to the full start count of ticks. The bench therefore counts ticks from every load or reload to the pulse, and it also checks that no second pulse follows.

A mask bit that is wrong becomes visible at the first event on that bit, as an early or late expiry. A wrong mode register is visible on `fastOff` one cycle after the write or break that should have set it.

// File: rtl/idle_timer_pkg.sv
package idle_timer_pkg;
  // Strobes from control to datapath; at most one is high in a cycle.
  typedef struct packed {
    logic load;    // start-count write: store and load
    logic reload;  // enabled activity: counter <= start count
    logic dec;     // minute tick on a nonzero counter
  } cntStrb_t;
endpackage

// File: rtl/idle_count_dp.sv
module idle_count_dp
  import idle_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrb_t         strb,
  input  logic [CNT_W-1:0] wrData,
  output logic             cntZero,
  output logic             expirePulse,
  output logic [CNT_W-1:0] cntVal,
  output logic [CNT_W-1:0] startVal
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] startReg;
  logic [CNT_W-1:0] cnt;
  logic             expQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startReg <= '0;
      cnt      <= '0;
      expQ     <= 1'b0;
    end else begin
      expQ <= 1'b0;
      if (strb.load) begin
        startReg <= wrData;
        cnt      <= wrData;
      end else if (strb.reload) begin
        cnt <= startReg;
      end else if (strb.dec) begin
        cnt  <= cnt - ONE;
        expQ <= (cnt == ONE);
      end
    end
  end

  assign cntZero     = (cnt == '0);
  assign expirePulse = expQ;
  assign cntVal      = cnt;
  assign startVal    = startReg;
endmodule

// File: rtl/idle_count_ctrl.sv
module idle_count_ctrl
  import idle_timer_pkg::*;
#(
  parameter int N_ACT = 9,
  parameter int N_BRK = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrStart,
  input  logic             wrActMask,
  input  logic [N_ACT-1:0] actMaskData,
  input  logic             wrBrkMask,
  input  logic [N_BRK-1:0] brkMaskData,
  input  logic             wrMode,
  input  logic             modeData,
  input  logic [N_ACT-1:0] actEvt,
  input  logic [N_BRK-1:0] brkEvt,
  input  logic             minuteTick,
  input  logic             cntZero,
  output cntStrb_t         strb,
  output logic             fastOff,
  output logic             brkHit
);
  logic [N_ACT-1:0] actMask;
  logic [N_BRK-1:0] brkMask;
  logic [N_ACT-1:0] actHitVec;
  logic [N_BRK-1:0] brkHitVec;
  logic             modeQ;
  logic             actHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actMask <= '0;
      brkMask <= '0;
    end else begin
      if (wrActMask) actMask <= actMaskData;
      if (wrBrkMask) brkMask <= brkMaskData;
    end
  end

  // Per-source qualification of the event levels by their enable bits.
  for (genvar i = 0; i < N_ACT; i++) begin : g_act
    assign actHitVec[i] = actEvt[i] & actMask[i];
  end
  for (genvar j = 0; j < N_BRK; j++) begin : g_brk
    assign brkHitVec[j] = brkEvt[j] & brkMask[j];
  end

  assign actHit = |actHitVec;
  assign brkHit = |brkHitVec;

  always_comb begin
    strb.load   = wrStart;
    strb.reload = !wrStart && actHit;
    strb.dec    = !wrStart && !actHit && minuteTick && !cntZero;
  end

  // Mode: software enters Fast Off; an enabled break forces Power On.
  always_ff @(posedge clk) begin
    if (!rstN)       modeQ <= 1'b0;
    else if (brkHit) modeQ <= 1'b0;
    else if (wrMode) modeQ <= modeData;
  end

  assign fastOff = modeQ;
endmodule

// File: rtl/idle_reload_timer.sv
module idle_reload_timer
  import idle_timer_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int N_ACT = 9,
  parameter int N_BRK = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrStart,
  input  logic [CNT_W-1:0] startData,
  input  logic             wrActMask,
  input  logic [N_ACT-1:0] actMaskData,
  input  logic             wrBrkMask,
  input  logic [N_BRK-1:0] brkMaskData,
  input  logic             wrMode,
  input  logic             modeData,
  input  logic [N_ACT-1:0] actEvt,
  input  logic [N_BRK-1:0] brkEvt,
  input  logic             minuteTick,
  output logic             expirePulse,
  output logic             fastOff
);
  cntStrb_t         strb;
  logic             cntZero;
  logic             brkHit;
  logic [CNT_W-1:0] cntVal;
  logic [CNT_W-1:0] startVal;

  idle_count_ctrl #(.N_ACT(N_ACT), .N_BRK(N_BRK)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrStart(wrStart),
    .wrActMask(wrActMask), .actMaskData(actMaskData),
    .wrBrkMask(wrBrkMask), .brkMaskData(brkMaskData),
    .wrMode(wrMode), .modeData(modeData),
    .actEvt(actEvt), .brkEvt(brkEvt), .minuteTick(minuteTick),
    .cntZero(cntZero), .strb(strb), .fastOff(fastOff), .brkHit(brkHit)
  );

  idle_count_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(startData),
    .cntZero(cntZero), .expirePulse(expirePulse),
    .cntVal(cntVal), .startVal(startVal)
  );
endmodule

// File: rtl/idle_timer_chk.sv
module idle_timer_chk
  import idle_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrStart,
  input logic [CNT_W-1:0] startData,
  input logic             minuteTick,
  input logic             wrMode,
  input logic             modeData,
  input cntStrb_t         strb,
  input logic             brkHit,
  input logic [CNT_W-1:0] cntVal,
  input logic [CNT_W-1:0] startVal,
  input logic             expirePulse,
  input logic             fastOff
);
  a_r2_load: assert property (@(posedge clk) disable iff (!rstN)
    wrStart |=> (cntVal == $past(startData)) && (startVal == $past(startData)));

  a_r5_reload: assert property (@(posedge clk) disable iff (!rstN)
    strb.reload |=> cntVal == $past(startVal));

  a_r3_dec: assert property (@(posedge clk) disable iff (!rstN)
    (minuteTick && !wrStart && !strb.reload && cntVal != '0)
      |=> cntVal == $past(cntVal) - CNT_W'(1));

  a_r3_hold_zero: assert property (@(posedge clk) disable iff (!rstN)
    (cntVal == '0 && !wrStart && !strb.reload) |=> cntVal == '0);

  a_r4_single: assert property (@(posedge clk) disable iff (!rstN)
    expirePulse |=> !expirePulse);

  a_r4_at_zero: assert property (@(posedge clk) disable iff (!rstN)
    expirePulse |-> cntVal == '0);

  a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strb.load, strb.reload, strb.dec}) <= 1);

  a_r10_break: assert property (@(posedge clk) disable iff (!rstN)
    brkHit |=> !fastOff);

  a_r9_mode_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrMode && !brkHit) |=> fastOff == $past(modeData));
endmodule

bind idle_reload_timer idle_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrStart(wrStart), .startData(startData),
  .minuteTick(minuteTick), .wrMode(wrMode), .modeData(modeData),
  .strb(strb), .brkHit(brkHit), .cntVal(cntVal), .startVal(startVal),
  .expirePulse(expirePulse), .fastOff(fastOff)
);

// File: tb/tb_idle_reload_timer.sv
`timescale 1ns/1ps
module tb_idle_reload_timer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrStart = 1'b0;
  logic [7:0] startData = '0;
  logic       wrActMask = 1'b0;
  logic [8:0] actMaskData = '0;
  logic       wrBrkMask = 1'b0;
  logic [3:0] brkMaskData = '0;
  logic       wrMode = 1'b0;
  logic       modeData = 1'b0;
  logic [8:0] actEvt = '0;
  logic [3:0] brkEvt = '0;
  logic       minuteTick = 1'b0;
  logic       expirePulse;
  logic       fastOff;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  idle_reload_timer dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, let the edge pass, sample 1 ns later, release.
  task automatic cycle(input logic tk, input logic [8:0] act, input logic [3:0] brk);
    @(negedge clk);
    minuteTick = tk; actEvt = act; brkEvt = brk;
    @(posedge clk); #1;
    minuteTick = 1'b0; actEvt = '0; brkEvt = '0;
    wrStart = 1'b0; wrActMask = 1'b0; wrBrkMask = 1'b0; wrMode = 1'b0;
  endtask

  task automatic writeStart(input logic [7:0] v, input logic tk);
    @(negedge clk);
    wrStart = 1'b1; startData = v;
    cycle(tk, '0, '0);
  endtask

  task automatic writeMasks(input logic [8:0] am, input logic [3:0] bm);
    @(negedge clk);
    wrActMask = 1'b1; actMaskData = am; wrBrkMask = 1'b1; brkMaskData = bm;
    cycle(1'b0, '0, '0);
  endtask

  // Issue n ticks; report the tick number of the first pulse and the pulse count.
  task automatic runTicks(input int n, output int first, output int cnt);
    first = 0; cnt = 0;
    for (int i = 1; i <= n; i++) begin
      cycle(1'b1, '0, '0);
      if (expirePulse) begin
        cnt++;
        if (first == 0) first = i;
      end
    end
    cycle(1'b0, '0, '0);
    if (expirePulse) cnt++;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin : main
    int first, cnt;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    // R1: reset state
    chk(expirePulse == 1'b0, "R1 pulse", int'(expirePulse), 0);
    chk(fastOff == 1'b0, "R1 mode", int'(fastOff), 0);
    runTicks(4, first, cnt);
    chk(cnt == 0, "R1 counter zero", cnt, 0);

    // R2 R3 R4: sweep start counts, expiry on tick N, exactly one pulse
    for (int s = 1; s <= 24; s++) begin
      writeStart(8'(s), 1'b0);
      runTicks(s + 3, first, cnt);
      chk(first == s, "R3 expiry tick", first, s);
      chk(cnt == 1, "R4 single pulse", cnt, 1);
    end
    writeStart(8'd255, 1'b0);
    runTicks(258, first, cnt);
    chk(first == 255 && cnt == 1, "R2 full-range load", first, 255);

    // R5 R6: each activity bit, enabled alone vs disabled alone
    for (int b = 0; b < 9; b++) begin
      writeMasks(9'(1 << b), '0);
      writeStart(8'd6, 1'b0);
      runTicks(3, first, cnt);
      cycle(1'b0, 9'(1 << b), '0);
      runTicks(9, first, cnt);
      chk(first == 6 && cnt == 1, $sformatf("R5 reload bit %0d", b), first, 6);
      writeMasks(~9'(1 << b), '0);
      writeStart(8'd6, 1'b0);
      runTicks(3, first, cnt);
      cycle(1'b0, 9'(1 << b), '0);
      runTicks(6, first, cnt);
      chk(first == 3 && cnt == 1, $sformatf("R6 masked bit %0d", b), first, 3);
    end

    // R5: reload after expiry restarts the count
    writeMasks(9'h1FF, '0);
    writeStart(8'd3, 1'b0);
    runTicks(5, first, cnt);
    cycle(1'b0, 9'h100, '0);
    runTicks(5, first, cnt);
    chk(first == 3 && cnt == 1, "R5 reload after expiry", first, 3);

    // R7: reload beats tick; start write beats tick
    writeStart(8'd4, 1'b0);
    runTicks(2, first, cnt);
    cycle(1'b1, 9'h001, '0);
    runTicks(6, first, cnt);
    chk(first == 4 && cnt == 1, "R7 reload over tick", first, 4);
    writeStart(8'd5, 1'b1);
    runTicks(7, first, cnt);
    chk(first == 5 && cnt == 1, "R7 write over tick", first, 5);
    writeStart(8'd2, 1'b0);
    @(negedge clk); wrStart = 1'b1; startData = 8'd7;
    cycle(1'b1, 9'h001, '0);
    runTicks(9, first, cnt);
    chk(first == 7 && cnt == 1, "R7 write over reload", first, 7);

    // R8: start of zero, loaded and reloaded
    writeStart(8'd0, 1'b0);
    runTicks(5, first, cnt);
    chk(cnt == 0, "R8 zero load", cnt, 0);
    cycle(1'b0, 9'h002, '0);
    runTicks(5, first, cnt);
    chk(cnt == 0, "R8 zero reload", cnt, 0);

    // R9 R10 R11: all break-mask / break-event combinations
    for (int m = 0; m < 16; m++) begin
      writeMasks(9'h1FF, 4'(m));
      for (int e = 0; e < 16; e++) begin
        @(negedge clk); wrMode = 1'b1; modeData = 1'b1;
        cycle(1'b0, '0, '0);
        chk(fastOff == 1'b1, "R9 enter fast off", int'(fastOff), 1);
        cycle(1'b0, 9'h1FF, 4'(e));
        chk(fastOff == ((m & e) == 0), $sformatf("R10/R11 m=%0d e=%0d", m, e),
            int'(fastOff), int'((m & e) == 0));
      end
    end
    @(negedge clk); wrMode = 1'b1; modeData = 1'b0;
    cycle(1'b0, '0, '0);
    chk(fastOff == 1'b0, "R9 write power on", int'(fastOff), 0);
    writeMasks(9'h1FF, 4'b0100);
    @(negedge clk); wrMode = 1'b1; modeData = 1'b1;
    cycle(1'b0, '0, 4'b0100);
    chk(fastOff == 1'b0, "R10 break over write", int'(fastOff), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule